// File: doc/BRIEF.md
# Tick Counter with Compare Interrupt

This block is a free-running cycle counter with one compare register. It is meant to sit beside a processor core. The counter advances by one on each pulse of a tick-rate clock enable, nominally 100 MHz.

Both registers are 64 bits wide when software sees them. The low 63 bits hold the count or the compare value. The top bit is a shared "interrupt disabled" flag, and every write loads it. When the counter is read back, the flag appears in the top bit.

Writing a nonzero compare value while the flag is clear arms a one-shot match. When the count reaches the compare value, the block sets a sticky match bit and sends a single-cycle wake pulse to the interrupt arbiter. The match bit stays set until software clears it with a separate strobe.

Top module: `tick_timer`

## Requirements
- R1: After reset the count is 0, the disabled flag is set (reading the counter gives 0x8000000000000000), no match is armed, `match_flag` is 0 and `wake` is 0.
- R2: On every cycle with `tick_en` high the count increases by one, whatever the disabled flag holds; with `tick_en` low it holds.
- R3: A write with `wr_sel`=0 loads bits 62:0 of `wr_data` as the count and bit 63 as the disabled flag. With `rd_sel`=0, `rd_data` returns the count in bits 62:0 and the disabled flag in bit 63.
- R4: A write with `wr_sel`=1 loads bits 62:0 as the compare value and bit 63 as the disabled flag. With `rd_sel`=1, `rd_data` returns the compare value with the flag in bit 63.
- R5: Once armed, the match fires on the `tick_en` cycle in which the count reaches or passes the compare value. At that same clock edge `match_flag` becomes 1 and `wake` goes high for exactly one cycle.
- R6: A compare value written while it is already at or behind the count fires on the next `tick_en` cycle.
- R7: Writing a compare value of zero never arms the match, and it cancels a match that is pending.
- R8: Writing a 1 into the flag through either register cancels a pending match and stops any match from firing while the flag is set.
- R9: `match_flag` stays set until a cycle with `match_clr` high. If a match fires in that same cycle, the set wins.
- R10: A match fires at most once per compare write. No further wake occurs until the compare register is written again.
- R11: The count wraps from 2^63-1 to 0.
- R12: A counter write in a cycle with `tick_en` high loads the written value; the tick is not applied to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Tick-rate clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 counter, 1 compare |
| wr_data | input | CNT_W+1 | Write value; top bit is the disabled flag |
| rd_sel | input | 1 | Read target: 0 counter, 1 compare |
| rd_data | output | CNT_W+1 | Read value with the flag merged into the top bit |
| match_clr | input | 1 | Clears the match bit |
| match_flag | output | 1 | Sticky tick-match bit |
| wake | output | 1 | One-cycle wake pulse to the interrupt arbiter |

## Verification
A corrupted count shows up at the counter read port in the very next cycle. A wrong arm state shows up only later, as a wake that is missing, early or duplicated. That wake appears on the `tick_en` cycle where the count reaches the compare value.

The directed scenarios therefore place the compare value a known number of ticks ahead of the count and sample `match_flag` and `wake` on both sides of the expected edge. Lost cancellation is exposed by ticking well past a cancelled compare value. A missing one-shot clear is exposed by ticking on after a clear strobe.

// File: rtl/tick_pkg.sv
package tick_pkg;
   typedef enum logic {
      SEL_COUNT = 1'b0,
      SEL_LIMIT = 1'b1
   } tick_sel_e;
endpackage

// File: rtl/tick_count.sv
module tick_count #(
   parameter int CNT_W = 63
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   // a load takes priority over the tick in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n)       count <= '0;
      else if (load)    count <= load_val;
      else if (tick_en) count <= count + ONE;
   end

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && tick_en) |=> (count == $past(count) + ONE)); // R2
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !tick_en) |=> $stable(count)); // R2
   AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (count == $past(load_val))); // R12
endmodule

// File: rtl/tick_cmp.sv
module tick_cmp #(
   parameter int CNT_W = 63
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             wr_cnt,
   input  logic             wr_lim,
   input  logic [CNT_W:0]   wr_data,
   input  logic [CNT_W-1:0] count,
   output logic             disabled,
   output logic [CNT_W-1:0] limit,
   output logic             fire
);
   localparam int EXT_W = CNT_W + 1;

   logic             armed;
   logic [EXT_W-1:0] next_cnt;
   logic             reached;
   logic             wr_flag;
   logic [CNT_W-1:0] wr_val;

   assign wr_flag  = wr_data[CNT_W];
   assign wr_val   = wr_data[CNT_W-1:0];
   assign next_cnt = {1'b0, count} + {{CNT_W{1'b0}}, 1'b1};
   assign reached  = next_cnt >= {1'b0, limit};
   // any register write in this cycle takes priority over the match
   assign fire     = armed && tick_en && reached && !wr_cnt && !wr_lim;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         disabled <= 1'b1;
         limit    <= '0;
         armed    <= 1'b0;
      end else if (wr_lim) begin
         limit    <= wr_val;
         disabled <= wr_flag;
         armed    <= !wr_flag && (wr_val != '0);
      end else if (wr_cnt) begin
         disabled <= wr_flag;
         if (wr_flag) armed <= 1'b0;
      end else if (fire) begin
         armed <= 1'b0;
      end
   end

   AST_NO_ARM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (limit != '0)); // R7
   AST_NO_ARM_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> !disabled); // R8
   AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !armed); // R10
endmodule

// File: rtl/tick_irq.sv
module tick_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic clr,
   output logic match_flag,
   output logic wake
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         match_flag <= 1'b0;
         wake       <= 1'b0;
      end else begin
         wake <= fire;
         if (fire)     match_flag <= 1'b1;
         else if (clr) match_flag <= 1'b0;
      end
   end

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (match_flag && !clr) |=> match_flag); // R9
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
   parameter int CNT_W = 63
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           tick_en,
   input  logic           wr_en,
   input  logic           wr_sel,
   input  logic [CNT_W:0] wr_data,
   input  logic           rd_sel,
   output logic [CNT_W:0] rd_data,
   input  logic           match_clr,
   output logic           match_flag,
   output logic           wake
);
   import tick_pkg::*;

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("tick_timer: CNT_W must be at least 2");
      end
   endgenerate

   tick_sel_e        wsel, rsel;
   logic             wr_cnt, wr_lim;
   logic [CNT_W-1:0] count, limit;
   logic             disabled, fire;

   assign wsel   = tick_sel_e'(wr_sel);
   assign rsel   = tick_sel_e'(rd_sel);
   assign wr_cnt = wr_en && (wsel == SEL_COUNT);
   assign wr_lim = wr_en && (wsel == SEL_LIMIT);

   tick_count #(.CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .load(wr_cnt), .load_val(wr_data[CNT_W-1:0]), .count(count)
   );

   tick_cmp #(.CNT_W(CNT_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .wr_cnt(wr_cnt), .wr_lim(wr_lim), .wr_data(wr_data),
      .count(count), .disabled(disabled), .limit(limit), .fire(fire)
   );

   tick_irq u_irq (
      .clk(clk), .rst_n(rst_n), .fire(fire), .clr(match_clr),
      .match_flag(match_flag), .wake(wake)
   );

   always_comb begin
      if (rsel == SEL_LIMIT) rd_data = {disabled, limit};
      else                   rd_data = {disabled, count};
   end

   AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wake |=> !wake); // R5
   AST_WAKE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> match_flag); // R9
   AST_NO_WAKE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      $past(disabled) |-> !wake); // R8
endmodule

// File: tb/tick_timer_test.sv
module tick_timer_test;
   localparam int CNT_W = 63;
   localparam logic [63:0] DIS = 64'h8000_0000_0000_0000;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           tick_en = 1'b0;
   logic           wr_en = 1'b0;
   logic           wr_sel = 1'b0;
   logic [CNT_W:0] wr_data = '0;
   logic           rd_sel = 1'b0;
   logic [CNT_W:0] rd_data;
   logic           match_clr = 1'b0;
   logic           match_flag;
   logic           wake;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   tick_timer #(.CNT_W(CNT_W)) uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
      .match_clr(match_clr), .match_flag(match_flag), .wake(wake)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0; match_clr = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic sel, input logic [63:0] val);
      wr_en = 1'b1; wr_sel = sel; wr_data = val;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         tick_en = 1'b1;
         @(negedge clk);
      end
      tick_en = 1'b0;
   endtask

   task automatic rd(input logic sel, output logic [63:0] v);
      rd_sel = sel;
      #1 v = rd_data;
   endtask

   task automatic t_reset();
      logic [63:0] v;
      do_reset();
      rd(1'b0, v); check("R1 count/flag", v, DIS);
      check("R1 match_flag", {63'b0, match_flag}, 64'd0);
      check("R1 wake", {63'b0, wake}, 64'd0);
      tick(40);
      check("R1 no match after reset", {63'b0, match_flag}, 64'd0);
   endtask

   task automatic t_count();
      logic [63:0] v;
      do_reset();
      tick(3);
      rd(1'b0, v); check("R2 counts while disabled", v, DIS | 64'd3);
      @(negedge clk); @(negedge clk);
      rd(1'b0, v); check("R2 holds without tick", v, DIS | 64'd3);
   endtask

   task automatic t_regs();
      logic [63:0] v;
      do_reset();
      wr(1'b0, 64'd1234);
      rd(1'b0, v); check("R3 counter load enabled", v, 64'd1234);
      wr(1'b0, DIS | 64'd77);
      rd(1'b0, v); check("R3 counter load disabled", v, DIS | 64'd77);
      wr(1'b1, 64'd999);
      rd(1'b1, v); check("R4 limit readback", v, 64'd999);
      wr(1'b1, DIS | 64'd555);
      rd(1'b1, v); check("R4 limit flag readback", v, DIS | 64'd555);
      rd(1'b0, v); check("R4 flag merged into counter", v, DIS | 64'd77);
   endtask

   task automatic t_match();
      do_reset();
      wr(1'b0, 64'd100);
      wr(1'b1, 64'd105);
      tick(4);
      check("R5 no early match", {62'b0, match_flag, wake}, 64'd0);
      tick(1);
      check("R5 wake at reach", {63'b0, wake}, 64'd1);
      check("R5 flag at reach", {63'b0, match_flag}, 64'd1);
      @(negedge clk);
      check("R5 wake one cycle", {63'b0, wake}, 64'd0);
      match_clr = 1'b1; @(negedge clk); match_clr = 1'b0;
      check("R9 clear strobe", {63'b0, match_flag}, 64'd0);
      tick(20);
      check("R10 one shot", {63'b0, match_flag}, 64'd0);
   endtask

   task automatic t_past();
      do_reset();
      wr(1'b0, 64'd500);
      wr(1'b1, 64'd200);
      check("R6 not before tick", {63'b0, match_flag}, 64'd0);
      tick(1);
      check("R6 fires next tick", {63'b0, wake}, 64'd1);
   endtask

   task automatic t_zero();
      do_reset();
      wr(1'b0, 64'd10);
      wr(1'b1, 64'd0);
      tick(8);
      check("R7 zero never arms", {63'b0, match_flag}, 64'd0);
      wr(1'b1, 64'd25);
      wr(1'b1, 64'd0);
      tick(30);
      check("R7 zero cancels pending", {63'b0, match_flag}, 64'd0);
   endtask

   task automatic t_disable();
      do_reset();
      wr(1'b0, 64'd10);
      wr(1'b1, DIS | 64'd15);
      tick(12);
      check("R8 disabled limit ignored", {63'b0, match_flag}, 64'd0);
      wr(1'b0, 64'd10);
      wr(1'b1, 64'd25);
      wr(1'b0, DIS | 64'd20);
      tick(12);
      check("R8 counter flag cancels", {63'b0, match_flag}, 64'd0);
   endtask

   task automatic t_setwins();
      do_reset();
      wr(1'b0, 64'd40);
      wr(1'b1, 64'd41);
      tick(1);
      check("R9 first fire", {63'b0, match_flag}, 64'd1);
      wr(1'b1, 64'd42);
      tick_en = 1'b1; match_clr = 1'b1;
      @(negedge clk);
      tick_en = 1'b0; match_clr = 1'b0;
      check("R9 set wins over clear", {63'b0, match_flag}, 64'd1);
      check("R10 rewrite rearms", {63'b0, wake}, 64'd1);
   endtask

   task automatic t_wrap();
      logic [63:0] v;
      do_reset();
      wr(1'b0, 64'h7FFF_FFFF_FFFF_FFFF);
      tick(1);
      rd(1'b0, v); check("R11 wrap to zero", v, 64'd0);
   endtask

   task automatic t_prio();
      logic [63:0] v;
      do_reset();
      tick_en = 1'b1;
      wr(1'b0, 64'd50);
      tick_en = 1'b0;
      rd(1'b0, v); check("R12 write beats tick", v, 64'd50);
   endtask

   initial begin
      t_reset();
      t_count();
      t_regs();
      t_match();
      t_past();
      t_zero();
      t_disable();
      t_setwins();
      t_wrap();
      t_prio();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule